// File: doc/BRIEF.md
# Branch Target Buffer with Two-Bit Direction Prediction

This block chooses the next fetch address for a scalar five-stage pipeline whose instruction set has no delay slot. In the same cycle that the fetch PC is presented, a small direct-mapped table is read. It returns either a stored target or the sequential address PC+4, so a correct guess costs no fetch cycle. The table holds conditional branches, direct jumps, calls and returns. Each entry stores a tag, a kind code and a target. Only conditional branches use the two-bit saturating counter that sets their direction.

The execute stage reports each resolved control-flow instruction over a valid/ready resolve stream. A beat carries the instruction PC, its kind, whether it was taken, its actual target and the next PC that fetch had predicted for it. The block never applies back-pressure: `res_ready` is always high and a beat is consumed in every cycle that `res_valid` is high. A beat updates or allocates the matching entry. When the predicted next PC differs from the actual one, the block raises `flush` for one cycle, together with the correct address on `redirect_pc`.

Top module: `btb_predictor`

## Requirements
- R1: After reset every lookup misses (`pred_hit` 0, `pred_taken` 0, `pred_pc` = fetch_pc+4), and `flush` is low.
- R2: An entry is selected by fetch_pc[IDX_W+1:2], and fetch_pc[ADDR_W-1:IDX_W+2] is its tag. A PC with the same index but a different tag misses. Allocating that PC replaces the entry.
- R3: Prediction is combinational from `fetch_pc`. On a miss, `pred_pc` = fetch_pc+4 in the same cycle.
- R4: A hit on a conditional entry (kind code 0) predicts taken, with the stored target, exactly when its counter is 2 or 3. At counter 0 or 1 it predicts PC+4.
- R5: A hit on an entry of kind 1 (jump), 2 (call) or 3 (return) always predicts taken, with the stored target. A resolve beat of these kinds counts as taken whatever `res_taken` says.
- R6: A taken resolve that misses the table allocates the entry, and a conditional entry starts with its counter at 2. A not-taken conditional resolve that misses allocates nothing.
- R7: On a conditional resolve that hits, the counter steps up by one when the branch was taken and down by one when it was not. It saturates at 3 and at 0.
- R8: A taken resolve that hits rewrites the stored target and kind, so a changed return address is predicted from then on.
- R9: The actual next PC is `res_target` when taken and `res_pc`+4 otherwise. When it differs from `res_pred_pc`, `flush` is high in the cycle after the beat and `redirect_pc` equals the actual next PC. When it matches, `flush` stays low.
- R10: `res_ready` is high in every cycle out of reset, and a beat is consumed in every cycle that `res_valid` is high.
- R11: A loop-closing branch that is always taken is predicted to its target from the second pass on. An inner skip branch that is never taken is predicted as PC+4. Neither causes a flush in steady state.
- R12: A table update from a resolve beat is visible to lookups from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | ADDR_W | Current fetch address |
| pred_pc | output | ADDR_W | Predicted next fetch address |
| pred_taken | output | 1 | Prediction chose a stored target |
| pred_hit | output | 1 | Fetch PC matched a valid entry |
| res_valid | input | 1 | Resolve beat present |
| res_ready | output | 1 | Resolve beat accepted (always high out of reset) |
| res_pc | input | ADDR_W | PC of the resolved instruction |
| res_kind | input | 2 | 0 conditional, 1 jump, 2 call, 3 return |
| res_taken | input | 1 | Conditional outcome |
| res_target | input | ADDR_W | Actual target address |
| res_pred_pc | input | ADDR_W | Next PC that fetch predicted for this instruction |
| flush | output | 1 | One-cycle mispredict flush |
| redirect_pc | output | ADDR_W | Correct next PC, meaningful while flush is high |

## Verification
The bench builds the block with IDX_W = 3, so the table has eight entries. With that size, two PCs in a short test address range share an index, which exercises tag aliasing and entry replacement. ADDR_W stays at 32 and the counter width at 2, so the bench walks the counter through both saturation limits and the crossing between taken and not taken. A two-branch loop then shows the steady state settling within a few passes.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    BK_COND = 2'd0,
    BK_JUMP = 2'd1,
    BK_CALL = 2'd2,
    BK_RET  = 2'd3
  } br_kind_e;
endpackage

// File: rtl/btb_ctr_next.sv
module btb_ctr_next #(
  parameter int CNT_W = 2
) (
  input  logic [CNT_W-1:0] cur,
  input  logic             taken,
  input  logic             alloc,
  output logic [CNT_W-1:0] nxt
);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(1) << (CNT_W - 1);

  always_comb begin
    if (alloc)                         nxt = CNT_INIT;
    else if (taken && cur != CNT_MAX)  nxt = cur + CNT_W'(1);
    else if (!taken && cur != '0)      nxt = cur - CNT_W'(1);
    else                               nxt = cur;
  end
endmodule

// File: rtl/btb_table.sv
module btb_table #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_pc,
  output logic              rd_hit,
  output logic [1:0]        rd_kind,
  output logic [ADDR_W-1:0] rd_target,
  output logic [CNT_W-1:0]  rd_ctr,
  input  logic [ADDR_W-1:0] up_pc,
  output logic              up_hit,
  output logic [CNT_W-1:0]  up_ctr,
  input  logic              wr_en,
  input  logic              wr_tgt_en,
  input  logic [1:0]        wr_kind,
  input  logic [ADDR_W-1:0] wr_target,
  input  logic [CNT_W-1:0]  wr_ctr
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W - 2;

  logic              v_q   [DEPTH];
  logic [TAG_W-1:0]  tag_q [DEPTH];
  logic [1:0]        kind_q[DEPTH];
  logic [ADDR_W-1:0] tgt_q [DEPTH];
  logic [CNT_W-1:0]  ctr_q [DEPTH];

  logic [IDX_W-1:0] rd_idx, up_idx;
  logic [TAG_W-1:0] rd_tag, up_tag;

  assign rd_idx = rd_pc[IDX_W+1:2];
  assign rd_tag = rd_pc[ADDR_W-1:IDX_W+2];
  assign up_idx = up_pc[IDX_W+1:2];
  assign up_tag = up_pc[ADDR_W-1:IDX_W+2];

  assign rd_hit    = v_q[rd_idx] && (tag_q[rd_idx] == rd_tag);
  assign rd_kind   = kind_q[rd_idx];
  assign rd_target = tgt_q[rd_idx];
  assign rd_ctr    = ctr_q[rd_idx];

  assign up_hit = v_q[up_idx] && (tag_q[up_idx] == up_tag);
  assign up_ctr = ctr_q[up_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < DEPTH; e++) begin
        v_q[e]    <= 1'b0;
        tag_q[e]  <= '0;
        kind_q[e] <= '0;
        tgt_q[e]  <= '0;
        ctr_q[e]  <= '0;
      end
    end else if (wr_en) begin
      v_q[up_idx]    <= 1'b1;
      tag_q[up_idx]  <= up_tag;
      kind_q[up_idx] <= wr_kind;
      ctr_q[up_idx]  <= wr_ctr;
      if (wr_tgt_en) tgt_q[up_idx] <= wr_target;
    end
  end
endmodule

// File: rtl/btb_resolve.sv
module btb_resolve #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic [ADDR_W-1:0] pc,
  input  logic [1:0]        kind,
  input  logic              taken_in,
  input  logic [ADDR_W-1:0] target,
  input  logic [ADDR_W-1:0] pred_pc,
  output logic              taken_eff,
  output logic              flush,
  output logic [ADDR_W-1:0] redirect_pc
);
  import btb_pkg::*;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic [ADDR_W-1:0] actual;
  logic              miss_pred;

  assign taken_eff = taken_in || (kind != BK_COND);
  assign actual    = taken_eff ? target : pc + STEP;
  assign miss_pred = beat && (actual != pred_pc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flush       <= 1'b0;
      redirect_pc <= '0;
    end else begin
      flush <= miss_pred;
      if (miss_pred) redirect_pc <= actual;
    end
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int CNT_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_pc,
  output logic [ADDR_W-1:0] pred_pc,
  output logic              pred_taken,
  output logic              pred_hit,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [ADDR_W-1:0] res_pc,
  input  logic [1:0]        res_kind,
  input  logic              res_taken,
  input  logic [ADDR_W-1:0] res_target,
  input  logic [ADDR_W-1:0] res_pred_pc,
  output logic              flush,
  output logic [ADDR_W-1:0] redirect_pc
);
  import btb_pkg::*;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  logic              lk_hit;
  logic [1:0]        lk_kind;
  logic [ADDR_W-1:0] lk_target;
  logic [CNT_W-1:0]  lk_ctr;
  logic              up_hit;
  logic [CNT_W-1:0]  up_ctr, ctr_nxt;
  logic              beat, taken_eff, wr_en;

  assign res_ready = 1'b1;
  assign beat      = res_valid && res_ready;

  btb_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .rd_pc(fetch_pc), .rd_hit(lk_hit), .rd_kind(lk_kind),
    .rd_target(lk_target), .rd_ctr(lk_ctr),
    .up_pc(res_pc), .up_hit(up_hit), .up_ctr(up_ctr),
    .wr_en(wr_en), .wr_tgt_en(taken_eff), .wr_kind(res_kind),
    .wr_target(res_target), .wr_ctr(ctr_nxt)
  );

  btb_ctr_next #(.CNT_W(CNT_W)) u_ctr (
    .cur(up_ctr), .taken(taken_eff), .alloc(!up_hit), .nxt(ctr_nxt)
  );

  btb_resolve #(.ADDR_W(ADDR_W)) u_res (
    .clk(clk), .rst_n(rst_n), .beat(beat),
    .pc(res_pc), .kind(res_kind), .taken_in(res_taken),
    .target(res_target), .pred_pc(res_pred_pc),
    .taken_eff(taken_eff), .flush(flush), .redirect_pc(redirect_pc)
  );

  assign wr_en = beat && (up_hit || taken_eff);

  always_comb begin
    pred_hit   = lk_hit;
    pred_taken = lk_hit && ((lk_kind != BK_COND) || lk_ctr[CNT_W-1]);
    pred_pc    = pred_taken ? lk_target : fetch_pc + STEP;
  end
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] fetch_pc,
  input logic [ADDR_W-1:0] pred_pc,
  input logic              pred_taken,
  input logic              pred_hit,
  input logic              res_valid,
  input logic              res_ready,
  input logic [ADDR_W-1:0] res_pc,
  input logic [1:0]        res_kind,
  input logic              res_taken,
  input logic [ADDR_W-1:0] res_target,
  input logic              flush,
  input logic [ADDR_W-1:0] redirect_pc
);
  // R3
  miss_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_taken |-> pred_pc == fetch_pc + ADDR_W'(4));

  // R4
  taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> pred_hit);

  // R9
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> $past(res_valid));

  // R9
  redirect_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> redirect_pc == $past((res_taken || res_kind != 2'd0) ? res_target
                                                                   : res_pc + ADDR_W'(4)));

  // R10
  ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_ready);
endmodule

bind btb_predictor btb_predictor_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_pc(pred_pc),
  .pred_taken(pred_taken), .pred_hit(pred_hit), .res_valid(res_valid),
  .res_ready(res_ready), .res_pc(res_pc), .res_kind(res_kind),
  .res_taken(res_taken), .res_target(res_target), .flush(flush),
  .redirect_pc(redirect_pc)
);

// File: tb/btb_predictor_bench.sv
module btb_predictor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int IW = 3;
  localparam int DEPTH = 1 << IW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] fetch_pc = '0, pred_pc, res_pc = '0, res_target = '0, res_pred_pc = '0;
  logic [AW-1:0] redirect_pc;
  logic          pred_taken, pred_hit, res_valid = 1'b0, res_ready, res_taken = 1'b0, flush;
  logic [1:0]    res_kind = '0;

  int checks = 0;
  int errors = 0;

  // behavioural model state
  bit          m_v   [DEPTH];
  int unsigned m_tag [DEPTH];
  int unsigned m_kind[DEPTH];
  int unsigned m_tgt [DEPTH];
  int          m_ctr [DEPTH];
  bit          e_flush = 0;
  int unsigned e_redir = 0;
  int unsigned obs_pred = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_predictor #(.ADDR_W(AW), .IDX_W(IW), .CNT_W(2)) u_btb_predictor (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_hit(pred_hit), .res_valid(res_valid),
    .res_ready(res_ready), .res_pc(res_pc), .res_kind(res_kind),
    .res_taken(res_taken), .res_target(res_target), .res_pred_pc(res_pred_pc),
    .flush(flush), .redirect_pc(redirect_pc)
  );

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // one clock: drive, compare against model, advance model
  task automatic step(string req, int unsigned fpc, bit rv = 0, int unsigned rpc = 0,
                      int unsigned rk = 0, bit rt = 0, int unsigned rtgt = 0,
                      int unsigned rpred = 0);
    int idx, ridx;
    bit hit, tk, teff, rhit;
    int unsigned exp_pp, actual;
    @(negedge clk);
    fetch_pc = fpc; res_valid = rv; res_pc = rpc; res_kind = rk[1:0];
    res_taken = rt; res_target = rtgt; res_pred_pc = rpred;
    #1;
    idx = (fpc >> 2) % DEPTH;
    hit = m_v[idx] && m_tag[idx] == (fpc >> (IW + 2));
    tk  = hit && (m_kind[idx] != 0 || m_ctr[idx] >= 2);
    exp_pp = tk ? m_tgt[idx] : fpc + 4;
    chk(req, "pred_hit", pred_hit, hit);
    chk(req, "pred_taken", pred_taken, tk);
    chk(req, "pred_pc", pred_pc, exp_pp);
    chk("R10", "res_ready", res_ready, 1);
    chk(req, "flush", flush, e_flush);
    if (e_flush) chk(req, "redirect_pc", redirect_pc, e_redir);
    obs_pred = pred_pc;
    teff = rt || rk != 0;
    actual = teff ? rtgt : rpc + 4;
    e_flush = rv && actual != rpred;
    if (e_flush) e_redir = actual;
    if (rv) begin
      ridx = (rpc >> 2) % DEPTH;
      rhit = m_v[ridx] && m_tag[ridx] == (rpc >> (IW + 2));
      if (rhit) begin
        m_kind[ridx] = rk;
        if (teff) m_tgt[ridx] = rtgt;
        if (rk == 0) m_ctr[ridx] = rt ? (m_ctr[ridx] < 3 ? m_ctr[ridx] + 1 : 3)
                                       : (m_ctr[ridx] > 0 ? m_ctr[ridx] - 1 : 0);
      end else if (teff) begin
        m_v[ridx] = 1; m_tag[ridx] = rpc >> (IW + 2); m_kind[ridx] = rk;
        m_tgt[ridx] = rtgt; m_ctr[ridx] = 2;
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_v[i] = 0; m_tag[i] = 0; m_kind[i] = 0; m_tgt[i] = 0; m_ctr[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    step("R1", 32'h100);
    chk("R1", "miss after reset", pred_hit, 0);
    chk("R1", "flush after reset", flush, 0);
    step("R3", 32'h3FC);
    chk("R3", "miss seq pc", pred_pc, 32'h400);

    // R6 not-taken miss: no allocation
    step("R6", 32'h0, 1, 32'h100, 0, 0, 32'h40, 32'h104);
    step("R6", 32'h100);
    chk("R6", "no alloc on not-taken", pred_hit, 0);

    // R6/R9 taken miss allocates at counter 2, mispredict flushes
    step("R9", 32'h0, 1, 32'h100, 0, 1, 32'h40, 32'h104);
    step("R12", 32'h100);
    chk("R9", "flush after mispredict", flush, 1);
    chk("R9", "redirect to target", redirect_pc, 32'h40);
    chk("R12", "new entry taken", pred_pc, 32'h40);

    // R7 counter walk
    step("R7", 32'h100, 1, 32'h100, 0, 0, 32'h40, 32'h40);   // 2->1
    step("R7", 32'h100);
    chk("R4", "counter 1 predicts seq", pred_pc, 32'h104);
    chk("R9", "redirect to fallthrough", redirect_pc, 32'h104);
    step("R7", 32'h100, 1, 32'h100, 0, 0, 32'h40, 32'h104); // 1->0
    step("R7", 32'h100, 1, 32'h100, 0, 0, 32'h40, 32'h104); // 0 stays
    step("R7", 32'h100, 1, 32'h100, 0, 1, 32'h40, 32'h104); // 0->1
    step("R7", 32'h100, 1, 32'h100, 0, 1, 32'h40, 32'h104); // 1->2
    step("R4", 32'h100);
    chk("R4", "counter 2 predicts taken", pred_pc, 32'h40);
    for (int k = 0; k < 3; k++) step("R7", 32'h100, 1, 32'h100, 0, 1, 32'h40, 32'h40);
    step("R7", 32'h100, 1, 32'h100, 0, 0, 32'h40, 32'h40);  // 3->2
    step("R7", 32'h100);
    chk("R7", "saturated counter still taken", pred_taken, 1);

    // R2 aliasing: same index, other tag
    step("R2", 32'h120);
    chk("R2", "alias misses", pred_hit, 0);
    step("R2", 32'h0, 1, 32'h120, 1, 1, 32'h300, 32'h124);
    step("R2", 32'h120);
    chk("R2", "alias replaced", pred_pc, 32'h300);
    step("R2", 32'h100);
    chk("R2", "old entry evicted", pred_hit, 0);

    // R5 call and return (return reported with res_taken 0)
    step("R5", 32'h0, 1, 32'h10C, 2, 1, 32'h800, 32'h110);
    step("R5", 32'h0, 1, 32'h804, 3, 0, 32'h110, 32'h808);
    step("R5", 32'h10C);
    chk("R5", "call target", pred_pc, 32'h800);
    step("R5", 32'h804);
    chk("R5", "return target", pred_pc, 32'h110);

    // R8 return target refresh
    step("R8", 32'h0, 1, 32'h804, 3, 1, 32'h210, 32'h110);
    step("R8", 32'h804);
    chk("R8", "refreshed target", pred_pc, 32'h210);

    // R9 correct prediction, no flush
    step("R9", 32'h0, 1, 32'h804, 3, 1, 32'h210, 32'h210);
    step("R9", 32'h0);
    chk("R9", "no flush on match", flush, 0);

    // R11 loop: skip at 0x208 never taken, closer at 0x214 back to 0x200
    for (int it = 0; it < 20; it++) begin
      int unsigned p1, p2;
      step("R11", 32'h208);
      p1 = obs_pred;
      step("R11", 32'h214, 1, 32'h208, 0, 0, 32'h210, p1);
      p2 = obs_pred;
      if (it >= 2) chk("R11", "no flush steady", flush, 0);
      step("R11", 32'h200, 1, 32'h214, 0, 1, 32'h200, p2);
      if (it >= 2) begin
        chk("R11", "skip predicted seq", p1, 32'h20C);
        chk("R11", "closer predicted taken", p2, 32'h200);
      end
    end
    step("R11", 32'h0);
    summary();
  end
endmodule